// File: doc/BRIEF.md
# PLL Configuration Register with Byte Staging and Lock

This block holds the configuration word for a phase-locked loop and drives its fields straight to the PLL as registered outputs. Each field is a separate output. The word packs four fields. From most to least significant they are a sticky lock bit, a two-bit clock-output drive mode, a PLL enable bit and a twelve-bit multiplication factor. The register answers at one word location on a simple request/acknowledge bus.

A strap input selects the bus width, and the block samples it only while reset is asserted. On a 16-bit bus, one write replaces the whole word. On an 8-bit bus, software first writes the low byte, which the block holds in a shadow latch without touching the outputs. Software then writes the high byte, and the full word moves to the outputs in one cycle, so the PLL never sees half of a new setting. The reset values of the enable bit and the multiplication factor also come from straps sampled during reset.

Once software sets the lock bit, the block ignores every later write until the next reset. Blocked accesses are still acknowledged, so the bus never stalls.

Top module: `pll_ctl_reg`

## Requirements
- R1: While reset is asserted the block samples the straps. After reset the lock bit and the drive mode are 0, the enable and the multiplication factor equal the strap inputs, and bus_ack is low.
- R2: In 16-bit mode, a write at the register address replaces the whole word in one step. Bit 15 is the lock, bits 14:13 the drive mode, bit 12 the enable and bits 11:0 the multiplication factor. The outputs show the new value in the cycle after the request.
- R3: A read returns the committed word on bus_rdata, with bus_ack high in the cycle after the request.
- R4: A request at any word address other than 0x0F8 gets no acknowledge and changes no output.
- R5: In 8-bit mode, a write at byte address 0x0F9 (the low byte, taken from bus_wdata[7:0]) goes only into the shadow latch and leaves every output unchanged.
- R6: In 8-bit mode, a write at byte address 0x0F8 (the high byte, taken from bus_wdata[7:0]) commits that byte together with the staged low byte, all in the same cycle.
- R7: A high-byte write with no low byte pending commits the new high byte with the current committed low byte.
- R8: A read after a low-byte write returns the committed word, not the staged byte.
- R9: Once the lock bit is 1, every later write is ignored until reset, but each access still gets a single-cycle acknowledge.
- R10: A change of the bus-width strap after reset has no effect on how writes are decoded.
- R11: Each accepted access produces exactly one acknowledge, one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the straps are sampled while it is high |
| strap_narrow | input | 1 | Bus width strap: 1 selects the 8-bit bus, 0 the 16-bit bus |
| strap_pen | input | 1 | Reset value of the PLL enable |
| strap_mf | input | 12 | Reset value of the multiplication factor |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 selects a write, 0 a read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 16 | Write data; in 8-bit mode only bits 7:0 are used |
| bus_rdata | output | 16 | Committed word, valid while bus_ack is high after a read |
| bus_ack | output | 1 | Single-cycle acknowledge |
| pll_wp | output | 1 | Lock bit |
| pll_drv | output | 2 | Clock-output drive mode |
| pll_en | output | 1 | PLL enable |
| pll_mf | output | 12 | Multiplication factor |

## Verification
Every result of this block is due one clock edge after the request: the acknowledge, the read data and any change of a PLL output. Each bench task drives a request on a falling edge and holds it across one rising edge. It withdraws the request on the following falling edge and samples all outputs there, half a period after they settle. Checks that something did not happen (a low byte staged, a foreign address, a locked write) compare the outputs at that same point with the value they held before the request.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int MF_W   = 12;
  localparam int DRV_W  = 2;

  typedef struct packed {
    logic             wp;
    logic [DRV_W-1:0] drv;
    logic             en;
    logic [MF_W-1:0]  mf;
  } pcr_word_t;
endpackage

// File: rtl/pcr_decode.sv
module pcr_decode #(
  parameter int ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h0F8
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              narrow,
  output logic              hit,
  output logic              wr_word,
  output logic              wr_hi,
  output logic              wr_lo,
  output logic              rd
);
  localparam int WA_W = ADDR_W - 1;
  logic [WA_W-1:0] base_word;
  assign base_word = BASE_ADDR[ADDR_W-1:1];

  always_comb begin
    hit     = sel && (addr[ADDR_W-1:1] == base_word);
    rd      = hit && !we;
    wr_word = hit && we && !narrow;
    wr_hi   = hit && we && narrow && !addr[0];
    wr_lo   = hit && we && narrow && addr[0];
  end
endmodule

// File: rtl/pcr_stage.sv
module pcr_stage #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              locked,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] lo_in,
  input  logic [BYTE_W-1:0] cur_lo,
  output logic [BYTE_W-1:0] lo_out
);
  logic [BYTE_W-1:0] shadow_q;
  logic              pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      pend_q   <= 1'b0;
    end else if (!locked) begin
      if (wr_lo) begin
        shadow_q <= lo_in;
        pend_q   <= 1'b1;
      end else if (wr_hi) begin
        pend_q   <= 1'b0;
      end
    end
  end

  assign lo_out = pend_q ? shadow_q : cur_lo;
endmodule

// File: rtl/pll_ctl_reg.sv
module pll_ctl_reg
  import pcr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h0F8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_narrow,
  input  logic              strap_pen,
  input  logic [MF_W-1:0]   strap_mf,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              pll_wp,
  output logic [DRV_W-1:0]  pll_drv,
  output logic              pll_en,
  output logic [MF_W-1:0]   pll_mf
);
  pcr_word_t         cfg_q;
  logic              narrow_q;
  logic              hit, wr_word, wr_hi, wr_lo, rd;
  logic [BYTE_W-1:0] lo_commit;

  pcr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr), .narrow(narrow_q),
    .hit(hit), .wr_word(wr_word), .wr_hi(wr_hi), .wr_lo(wr_lo), .rd(rd)
  );

  pcr_stage #(.BYTE_W(BYTE_W)) u_stage (
    .clk(clk), .rst(rst), .locked(cfg_q.wp),
    .wr_lo(wr_lo), .wr_hi(wr_hi),
    .lo_in(bus_wdata[BYTE_W-1:0]),
    .cur_lo(cfg_q[BYTE_W-1:0]),
    .lo_out(lo_commit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '{wp: 1'b0, drv: '0, en: strap_pen, mf: strap_mf};
      narrow_q  <= strap_narrow;
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= hit;
      if (rd) bus_rdata <= cfg_q;
      if (!cfg_q.wp) begin
        if (wr_word)    cfg_q <= pcr_word_t'(bus_wdata);
        else if (wr_hi) cfg_q <= pcr_word_t'({bus_wdata[BYTE_W-1:0], lo_commit});
      end
    end
  end

  assign pll_wp  = cfg_q.wp;
  assign pll_drv = cfg_q.drv;
  assign pll_en  = cfg_q.en;
  assign pll_mf  = cfg_q.mf;
endmodule

// File: rtl/pll_ctl_reg_chk.sv
module pll_ctl_reg_chk
  import pcr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h0F8
) (
  input logic              clk,
  input logic              rst,
  input logic              narrow_q,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              pll_wp,
  input logic [DRV_W-1:0]  pll_drv,
  input logic              pll_en,
  input logic [MF_W-1:0]   pll_mf
);
  logic match;
  assign match = bus_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1];

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!pll_wp && pll_drv == '0 && !bus_ack));

  // R11
  ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ack |-> $past(bus_sel && match));

  // R4
  foreign_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !match) |=> (!bus_ack && $stable({pll_wp, pll_drv, pll_en, pll_mf})));

  // R5
  low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && narrow_q && match && bus_addr[0])
      |=> $stable({pll_wp, pll_drv, pll_en, pll_mf}));

  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pll_wp |=> (pll_wp && $stable({pll_drv, pll_en, pll_mf})));
endmodule

bind pll_ctl_reg pll_ctl_reg_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst(rst), .narrow_q(narrow_q),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_ack(bus_ack),
  .pll_wp(pll_wp), .pll_drv(pll_drv), .pll_en(pll_en), .pll_mf(pll_mf)
);

// File: tb/tb_pll_ctl_reg.sv
module tb_pll_ctl_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_narrow = 1'b0;
  logic        strap_pen = 1'b1;
  logic [11:0] strap_mf = 12'h123;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_ack;
  logic        pll_wp;
  logic [1:0]  pll_drv;
  logic        pll_en;
  logic [11:0] pll_mf;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pll_ctl_reg dut (
    .clk(clk), .rst(rst), .strap_narrow(strap_narrow), .strap_pen(strap_pen),
    .strap_mf(strap_mf), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .pll_wp(pll_wp), .pll_drv(pll_drv), .pll_en(pll_en), .pll_mf(pll_mf)
  );

  function automatic logic [15:0] outw();
    return {pll_wp, pll_drv, pll_en, pll_mf};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic narrow);
    @(negedge clk);
    strap_narrow = narrow;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic access(input logic we, input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    check("R1 word", outw(), 16'h1123);
    check("R1 ack", {15'd0, bus_ack}, 16'd0);
  endtask

  task automatic t_wide();
    access(1'b1, 12'h0F8, 16'h2ABC);
    check("R2 word", outw(), 16'h2ABC);
    check("R2 drv", {14'd0, pll_drv}, 16'd1);
    check("R11 ack", {15'd0, bus_ack}, 16'd1);
    @(negedge clk);
    check("R11 ack single", {15'd0, bus_ack}, 16'd0);
    access(1'b0, 12'h0F8, 16'h0);
    check("R3 rdata", bus_rdata, 16'h2ABC);
    check("R3 ack", {15'd0, bus_ack}, 16'd1);
  endtask

  task automatic t_foreign();
    access(1'b1, 12'h0FA, 16'h0F0F);
    check("R4 word", outw(), 16'h2ABC);
    check("R4 ack", {15'd0, bus_ack}, 16'd0);
  endtask

  task automatic t_narrow();
    do_reset(1'b1);
    check("R1 word narrow", outw(), 16'h1123);
    access(1'b1, 12'h0F9, 16'h0077);
    check("R5 low staged", outw(), 16'h1123);
    access(1'b0, 12'h0F8, 16'h0);
    check("R8 read committed", bus_rdata, 16'h1123);
    access(1'b1, 12'h0F8, 16'h0045);
    check("R6 commit", outw(), 16'h4577);
    strap_narrow = 1'b0;
    access(1'b1, 12'h0F8, 16'hAB31);
    check("R7 hi only", outw(), 16'h3177);
    check("R10 width kept", outw(), 16'h3177);
  endtask

  task automatic t_lock();
    access(1'b1, 12'h0F9, 16'h0000);
    access(1'b1, 12'h0F8, 16'h0080);
    check("R9 lock set", outw(), 16'h8000);
    access(1'b1, 12'h0F9, 16'h00FF);
    check("R9 low blocked", outw(), 16'h8000);
    access(1'b1, 12'h0F8, 16'h0012);
    check("R9 hi blocked", outw(), 16'h8000);
    check("R9 ack", {15'd0, bus_ack}, 16'd1);
    access(1'b0, 12'h0F8, 16'h0);
    check("R9 read", bus_rdata, 16'h8000);
  endtask

  initial begin
    t_reset();
    t_wide();
    t_foreign();
    t_narrow();
    t_lock();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule